// File: doc/BRIEF.md
# SPI Serial Memory Command Controller

This block is the slave side of a serial memory that sits on an SPI bus in clock mode 0 or mode 3. It runs on a system clock, oversamples the bus pins, and decodes each chip-select framed transaction: a one-byte command, then a 16-bit address where one is needed, then data. The address and data fields go MSB first. The behavioural byte array holds `2**ADDR_W` bytes. The default is kept small, and `ADDR_W = 13` gives the full 8192-byte map.

Reads return array bytes one after another for as long as the host keeps clocking. Writes gather up to one page of bytes in a staging buffer. They are committed only when chip select rises exactly on a byte boundary, with at least one data byte received. A write that commits starts a timed busy period, counted in system clocks. During that period the array is closed to new commands, but the status byte can still be read.

A small protection unit decides whether a commit may go ahead. It uses the write-enable latch, two region-lock bits and a status-lock bit, which is qualified by an active-low write-protect pin.

Top module: `serial_mem_ctrl`

## Requirements
- R1: Command codes are 03h read, 02h write, 06h enable writes, 04h disable writes, 05h read status and 01h write status. MOSI is sampled on rising SCK and MISO changes after falling SCK. All fields are MSB first.
- R2: Read takes a 16-bit address whose bits above ADDR_W-1 are ignored. Data starts at the first falling SCK after the address. The address advances after every byte and wraps from `2**ADDR_W-1` to 0.
- R3: For a write, the low 5 address bits (the column in a 32-byte page) advance per data byte and wrap from 31 to 0 inside the same page. A later byte for the same column replaces the earlier one.
- R4: A write commits only if chip select rises with a whole number of data bytes (at least one) received. Rising at any other point leaves the array, the busy flag and the enable latch unchanged.
- R5: Enable and disable take effect only when chip select rises directly after their eighth bit. A ninth bit or a missing bit cancels them. The latch shows as status bit 1.
- R6: A write without the enable latch set is discarded. When a committed write's busy period ends, the enable latch is cleared.
- R7: After a commit, status bit 0 reads 1 for BUSY_CYCLES clocks. The status byte stays readable during that time. A read or write command that starts while busy is ignored: MISO stays disabled and the array is unchanged.
- R8: Status bits 3:2 lock address regions against writes: 00 none, 01 the top quarter, 10 the top half, 11 the whole array. A write to a locked page is dropped with no busy period, and the enable latch is kept.
- R9: Write status updates bits 7 and 3:2 and starts a busy period. It is refused (no change, no busy) while bit 7 is 1 and `wp_n` is low.
- R10: MISO output enable is low whenever chip select is high. It stays low for an unknown command.
- R11: After reset, no command is decoded until a falling edge of chip select has been seen.
- R12: Mode 3 (SCK idle high) gives the same results as mode 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low write-protect pin for the status lock |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for spi_miso (low means high impedance) |

## Verification
The hardest situation to reach from the ports is a command that arrives while the timed busy period is still running. The bench reaches it by issuing a read or a second write straight after the commit that starts busy, and the bench's busy parameter is long enough that the new command is decoded before the period ends. Only after that does the bench poll the status byte until it goes idle and read the array back. Chip select rising one partial byte late is the other narrow case. The bench drives a bit count that is not a multiple of eight before raising chip select.

// File: rtl/smc_pkg.sv
package smc_pkg;

  typedef enum logic [7:0] {
    OP_WRSR  = 8'h01,
    OP_WRITE = 8'h02,
    OP_READ  = 8'h03,
    OP_WRDI  = 8'h04,
    OP_RDSR  = 8'h05,
    OP_WREN  = 8'h06
  } smc_op_e;

  // status byte: [7] status lock, [3:2] region lock, [1] enable latch, [0] busy
  function automatic logic [7:0] pack_status(logic lock, logic [1:0] region,
                                             logic wel, logic busy);
    return {lock, 3'b000, region, wel, busy};
  endfunction

  // region lock decode on the two top address bits
  function automatic logic region_locked(logic [1:0] region, logic [1:0] top2);
    case (region)
      2'b00:   return 1'b0;
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/smc_sync.sv
module smc_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] meta, prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
      prev <= '0;
    end else begin
      meta <= d;
      q    <= meta;
      prev <= q;
    end
  end

  assign rise = q & ~prev;
  assign fall = ~q & prev;
endmodule

// File: rtl/smc_protect.sv
module smc_protect import smc_pkg::*; (
  input  logic       wel,
  input  logic       lock_bit,
  input  logic [1:0] region,
  input  logic       wp_n,
  input  logic [1:0] page_top2,
  output logic       arr_ok,
  output logic       sts_ok,
  output logic       page_locked
);
  assign page_locked = region_locked(region, page_top2);
  assign arr_ok      = wel && !page_locked;
  assign sts_ok      = wel && !(lock_bit && !wp_n);
endmodule

// File: rtl/smc_busy_timer.sv
module smc_busy_timer #(
  parameter int CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             left <= '0;
    else if (start)         left <= CW'(CYCLES);
    else if (left != '0)    left <= left - 1'b1;
  end

  assign busy = left != '0;
  assign done = left == CW'(1);
endmodule

// File: rtl/smc_store.sv
module smc_store #(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        buf_clr,
  input  logic                        buf_we,
  input  logic [$clog2(PAGE_BYTES)-1:0] buf_col,
  input  logic [7:0]                  buf_data,
  input  logic                        commit,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] commit_page,
  input  logic [ADDR_W-1:0]           rd_addr,
  output logic [7:0]                  rd_data
);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int DEPTH   = 1 << ADDR_W;

  logic [7:0]            pbuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] vld;
  logic [7:0]            mem  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= '0;
    else if (buf_clr) vld <= '0;
    else if (buf_we) vld[buf_col] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_col] <= buf_data;
  end

  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (vld[i]) mem[{commit_page, PAGE_AW'(i)}] <= pbuf[i];
      end
    end
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serial_mem_ctrl.sv
module serial_mem_ctrl import smc_pkg::*; #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_BYTES  = 32,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_csn,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int PAGE_AW = $clog2(PAGE_BYTES);
  localparam int PG_W    = ADDR_W - PAGE_AW;

  function automatic logic [ADDR_W-1:0] read_step(logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [PAGE_AW-1:0] col_step(logic [PAGE_AW-1:0] c);
    return c + 1'b1;
  endfunction

  // pin synchronisers: [2] csn, [1] sck, [0] mosi
  logic [2:0] pin_q, pin_rise, pin_fall;
  smc_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({spi_csn, spi_sck, spi_mosi}),
    .q(pin_q), .rise(pin_rise), .fall(pin_fall)
  );

  logic csn_q, mosi_q, cs_fall, cs_rise;
  assign csn_q   = pin_q[2];
  assign mosi_q  = pin_q[0];
  assign cs_fall = pin_fall[2];

  logic active;
  assign cs_rise = pin_rise[2] && active;

  logic sck_rise, sck_fall;
  assign sck_rise = pin_rise[1] && active && !csn_q;
  assign sck_fall = pin_fall[1] && active && !csn_q;

  // frame state
  logic [ADDR_W-2:0]   sr_in;
  logic [2:0]          bitc, bytec;
  logic [7:0]          opcode;
  logic                blocked;
  logic [ADDR_W-1:0]   addr_ptr;
  logic [PG_W-1:0]     page_q;
  logic [PAGE_AW-1:0]  col_q;
  logic                sts_new_lock;
  logic [1:0]          sts_new_region;
  logic                lock_q, wel;
  logic [1:0]          region_q;
  logic                so_bit, so_oe;
  logic [7:0]          out_sr;

  logic [7:0]        byte_val;
  logic [ADDR_W-1:0] frame_addr;
  logic              byte_done, at_boundary;
  assign byte_val    = {sr_in[6:0], mosi_q};
  assign frame_addr  = {sr_in, mosi_q};
  assign byte_done   = sck_rise && bitc == 3'd7;
  assign at_boundary = bitc == 3'd0;

  // named internal events
  logic busy, busy_done, arr_ok, sts_ok, page_locked;
  logic ev_opcode, ev_addr, ev_wbyte;
  logic ev_commit_array, ev_commit_status, ev_wel_set, ev_wel_clr;

  assign ev_opcode = byte_done && bytec == 3'd0;
  assign ev_addr   = byte_done && bytec == 3'd2 &&
                     (opcode == OP_READ || opcode == OP_WRITE);
  assign ev_wbyte  = byte_done && bytec >= 3'd3 && opcode == OP_WRITE && !blocked;

  assign ev_commit_array  = cs_rise && opcode == OP_WRITE && !blocked &&
                            at_boundary && bytec >= 3'd4 && arr_ok;
  assign ev_commit_status = cs_rise && opcode == OP_WRSR && !blocked &&
                            at_boundary && bytec == 3'd2 && sts_ok;
  assign ev_wel_set = cs_rise && opcode == OP_WREN && !blocked &&
                      at_boundary && bytec == 3'd1;
  assign ev_wel_clr = cs_rise && opcode == OP_WRDI && !blocked &&
                      at_boundary && bytec == 3'd1;

  smc_protect u_prot (
    .wel(wel), .lock_bit(lock_q), .region(region_q), .wp_n(wp_n),
    .page_top2(page_q[PG_W-1 -: 2]),
    .arr_ok(arr_ok), .sts_ok(sts_ok), .page_locked(page_locked)
  );

  smc_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(ev_commit_array || ev_commit_status),
    .busy(busy), .done(busy_done)
  );

  logic [7:0] rd_data;
  smc_store #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n),
    .buf_clr(ev_opcode && byte_val == OP_WRITE),
    .buf_we(ev_wbyte), .buf_col(col_q), .buf_data(byte_val),
    .commit(ev_commit_array), .commit_page(page_q),
    .rd_addr(addr_ptr), .rd_data(rd_data)
  );

  // session and bit counting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      bitc   <= '0;
      bytec  <= '0;
      sr_in  <= '0;
    end else begin
      if (cs_fall)      active <= 1'b1;
      else if (cs_rise) active <= 1'b0;
      if (cs_fall) begin
        bitc  <= '0;
        bytec <= '0;
      end else if (sck_rise) begin
        sr_in <= {sr_in[ADDR_W-3:0], mosi_q};
        bitc  <= bitc + 1'b1;
        if (bitc == 3'd7 && bytec != 3'd7) bytec <= bytec + 1'b1;
      end
    end
  end

  // command fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode         <= '0;
      blocked        <= 1'b0;
      page_q         <= '0;
      col_q          <= '0;
      sts_new_lock   <= 1'b0;
      sts_new_region <= '0;
    end else begin
      if (ev_opcode) begin
        opcode  <= byte_val;
        blocked <= busy;
      end
      if (ev_addr) begin
        page_q <= frame_addr[ADDR_W-1:PAGE_AW];
        col_q  <= frame_addr[PAGE_AW-1:0];
      end else if (ev_wbyte) begin
        col_q <= col_step(col_q);
      end
      if (byte_done && bytec == 3'd1 && opcode == OP_WRSR) begin
        sts_new_lock   <= byte_val[7];
        sts_new_region <= byte_val[3:2];
      end
    end
  end

  // status and enable latch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      lock_q   <= 1'b0;
      region_q <= '0;
    end else begin
      if (busy_done)       wel <= 1'b0;
      else if (ev_wel_set) wel <= 1'b1;
      else if (ev_wel_clr) wel <= 1'b0;
      if (ev_commit_status) begin
        lock_q   <= sts_new_lock;
        region_q <= sts_new_region;
      end
    end
  end

  // output shifter
  logic       rd_phase, st_phase;
  logic [7:0] load_byte;
  assign rd_phase  = opcode == OP_READ && !blocked && bytec >= 3'd3;
  assign st_phase  = opcode == OP_RDSR && bytec >= 3'd1;
  assign load_byte = rd_phase ? rd_data : pack_status(lock_q, region_q, wel, busy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      so_oe    <= 1'b0;
      so_bit   <= 1'b0;
      out_sr   <= '0;
      addr_ptr <= '0;
    end else begin
      if (ev_addr) addr_ptr <= frame_addr;
      if (cs_rise || cs_fall) begin
        so_oe <= 1'b0;
      end else if (sck_fall && (rd_phase || st_phase)) begin
        so_oe <= 1'b1;
        if (at_boundary) begin
          so_bit <= load_byte[7];
          out_sr <= {load_byte[6:0], 1'b0};
          if (rd_phase) addr_ptr <= read_step(addr_ptr);
        end else begin
          so_bit <= out_sr[7];
          out_sr <= {out_sr[6:0], 1'b0};
        end
      end
    end
  end

  assign spi_miso    = so_oe ? so_bit : 1'b0;
  assign spi_miso_oe = so_oe;
endmodule

// File: rtl/smc_checker.sv
module smc_checker (
  input logic clk,
  input logic rst_n,
  input logic active,
  input logic cs_rise,
  input logic spi_miso_oe,
  input logic busy,
  input logic busy_done,
  input logic wel,
  input logic ev_commit_array,
  input logic ev_commit_status,
  input logic ev_wel_set
);
  a_r10_oe_drops_on_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !spi_miso_oe);

  a_r10_oe_only_in_session: assert property (@(posedge clk) disable iff (!rst_n)
    spi_miso_oe |-> active);

  a_r7_commit_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit_array || ev_commit_status) |-> !busy);

  a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_commit_array || ev_commit_status) |=> busy);

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_done) |=> busy);

  a_r6_wel_cleared_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    busy_done |=> !wel);

  a_r5_wel_set_takes: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wel_set |=> wel);

  a_r6_wel_steady_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !busy_done) |=> $stable(wel));
endmodule

bind serial_mem_ctrl smc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .active(active), .cs_rise(cs_rise),
  .spi_miso_oe(spi_miso_oe), .busy(busy), .busy_done(busy_done), .wel(wel),
  .ev_commit_array(ev_commit_array), .ev_commit_status(ev_commit_status),
  .ev_wel_set(ev_wel_set)
);

// File: tb/serial_mem_ctrl_test.sv
module serial_mem_ctrl_test;
  localparam int AW   = 11;
  localparam int BUSY = 600;
  localparam int H    = 5;
  localparam logic [15:0] TOP = 16'((1 << AW) - 1);

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, sck, csn, mosi, wp_n;
  logic miso, miso_oe;
  int   checks = 0, fails = 0;
  logic mode3 = 1'b0;
  logic oe_seen;
  logic [7:0] txq [64];
  logic [7:0] rxq [64];

  serial_mem_ctrl #(.ADDR_W(AW), .PAGE_BYTES(32), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
    .wp_n(wp_n), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic cs_low();
    sck = mode3;
    wclk(2);
    csn = 1'b0;
    wclk(4);
    oe_seen = 1'b0;
  endtask

  task automatic cs_high();
    wclk(4);
    csn = 1'b1;
    wclk(8);
    sck = mode3;
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
    rx = '0;
    for (int i = 0; i < nbits; i++) begin
      if (mode3) sck = 1'b0;
      mosi = tx[7-i];
      wclk(H);
      rx[7-i] = miso;
      if (miso_oe) oe_seen = 1'b1;
      sck = 1'b1;
      wclk(H);
      if (!mode3) sck = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_low(); xfer(op, d, 8); cs_high();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_low(); xfer(8'h05, d, 8); xfer(8'h00, st, 8); cs_high();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    cs_low(); xfer(8'h01, d, 8); xfer(v, d, 8); cs_high();
  endtask

  task automatic write_mem(input logic [15:0] a, input int n, input int extra);
    logic [7:0] d;
    cs_low();
    xfer(8'h02, d, 8); xfer(a[15:8], d, 8); xfer(a[7:0], d, 8);
    for (int i = 0; i < n; i++) xfer(txq[i], d, 8);
    if (extra > 0) xfer(8'hFF, d, extra);
    cs_high();
  endtask

  task automatic read_mem(input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_low();
    xfer(8'h03, d, 8); xfer(a[15:8], d, 8); xfer(a[7:0], d, 8);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, d, 8);
      rxq[i] = d;
    end
    cs_high();
  endtask

  task automatic wait_idle();
    logic [7:0] st;
    for (int i = 0; i < 40; i++) begin
      rdsr(st);
      if (!st[0]) break;
    end
  endtask

  task automatic put1(input logic [15:0] a, input logic [7:0] v);
    txq[0] = v;
    cmd1(8'h06); write_mem(a, 1, 0); wait_idle();
  endtask

  // R11: chip select held low through reset must not let a command in
  task automatic t_reset();
    logic [7:0] st, d;
    check("R10 oe low after reset", 32'(miso_oe), 32'd0);
    xfer(8'h06, d, 8);
    cs_high();
    rdsr(st);
    check("R11 no command before first cs fall", 32'(st), 32'h00);
  endtask

  // R5: enable and disable only at exactly eight bits
  task automatic t_wel();
    logic [7:0] st, d;
    cmd1(8'h06); rdsr(st);
    check("R5 enable sets status bit 1", 32'(st), 32'h02);
    cmd1(8'h04); rdsr(st);
    check("R5 disable clears status bit 1", 32'(st), 32'h00);
    cs_low(); xfer(8'h06, d, 8); xfer(8'h00, d, 1); cs_high(); rdsr(st);
    check("R5 ninth bit cancels enable", 32'(st), 32'h00);
    cs_low(); xfer(8'h06, d, 7); cs_high(); rdsr(st);
    check("R5 seven bits cancel enable", 32'(st), 32'h00);
  endtask

  // R1 R2 R6 R7: basic write, busy flag, locked read, read back
  task automatic t_write_read();
    logic [7:0] st;
    txq[0] = 8'h11; txq[1] = 8'h22; txq[2] = 8'h33;
    cmd1(8'h06);
    write_mem(16'hE105, 3, 0);
    rdsr(st);
    check("R7 busy and enable shown during write", 32'(st), 32'h03);
    read_mem(16'h0105, 1);
    check("R7 read while busy keeps miso disabled", 32'(oe_seen), 32'd0);
    wait_idle();
    rdsr(st);
    check("R6 enable latch cleared after busy", 32'(st), 32'h00);
    read_mem(16'h0105, 3);
    check("R10 oe driven during read data", 32'(oe_seen), 32'd1);
    check("R1 R2 read byte 0", 32'(rxq[0]), 32'h11);
    check("R2 read byte 1 sequential", 32'(rxq[1]), 32'h22);
    check("R2 read byte 2 sequential", 32'(rxq[2]), 32'h33);
  endtask

  // R3: column wrap inside a page and overwrite
  task automatic t_page_wrap();
    txq[0] = 8'hA1; txq[1] = 8'hA2; txq[2] = 8'hA3; txq[3] = 8'hA4;
    cmd1(8'h06); write_mem(16'h023E, 4, 0); wait_idle();
    read_mem(16'h023E, 2);
    check("R3 column 30", 32'(rxq[0]), 32'hA1);
    check("R3 column 31", 32'(rxq[1]), 32'hA2);
    read_mem(16'h0220, 2);
    check("R3 wrap to column 0", 32'(rxq[0]), 32'hA3);
    check("R3 wrap to column 1", 32'(rxq[1]), 32'hA4);
    for (int i = 0; i < 33; i++) txq[i] = 8'(i + 1);
    cmd1(8'h06); write_mem(16'h0240, 33, 0); wait_idle();
    read_mem(16'h0240, 3);
    check("R3 later byte overwrites column 0", 32'(rxq[0]), 32'h21);
    check("R3 column 1 kept", 32'(rxq[1]), 32'h02);
    check("R3 column 2 kept", 32'(rxq[2]), 32'h03);
  endtask

  // R4 R6: partial byte, cut address, missing enable
  task automatic t_discard();
    logic [7:0] st, d;
    put1(16'h0400, 8'h11);
    txq[0] = 8'h55;
    cmd1(8'h06); write_mem(16'h0400, 1, 3); rdsr(st);
    check("R4 partial byte: no busy, latch kept", 32'(st), 32'h02);
    read_mem(16'h0400, 1);
    check("R4 partial byte leaves array", 32'(rxq[0]), 32'h11);
    cs_low(); xfer(8'h02, d, 8); xfer(8'h04, d, 8); cs_high(); rdsr(st);
    check("R4 cut address: no busy", 32'(st), 32'h02);
    cmd1(8'h04);
    txq[0] = 8'h66;
    write_mem(16'h0400, 1, 0); rdsr(st);
    check("R6 write without enable: no busy", 32'(st), 32'h00);
    read_mem(16'h0400, 1);
    check("R6 write without enable leaves array", 32'(rxq[0]), 32'h11);
  endtask

  // R7: second write during busy is ignored
  task automatic t_busy_lock();
    txq[0] = 8'h66; txq[1] = 8'h44;
    cmd1(8'h06); write_mem(16'h0080, 2, 0); wait_idle();
    txq[0] = 8'h77;
    cmd1(8'h06); write_mem(16'h0080, 1, 0);
    txq[0] = 8'h99;
    write_mem(16'h0081, 1, 0);
    wait_idle();
    read_mem(16'h0080, 2);
    check("R7 first write landed", 32'(rxq[0]), 32'h77);
    check("R7 write during busy ignored", 32'(rxq[1]), 32'h44);
  endtask

  // R2: sequential read wraps at the top address
  task automatic t_read_wrap();
    put1(TOP, 8'h9A);
    put1(16'h0000, 8'h5B);
    read_mem(TOP, 2);
    check("R2 top address", 32'(rxq[0]), 32'h9A);
    check("R2 wrap to address 0", 32'(rxq[1]), 32'h5B);
  endtask

  // R8: region locks
  task automatic t_protect();
    logic [7:0] st;
    put1(16'h0600, 8'h3C);
    cmd1(8'h06); wrsr(8'h04); wait_idle(); rdsr(st);
    check("R8 region bits written", 32'(st), 32'h04);
    txq[0] = 8'hC3;
    cmd1(8'h06); write_mem(16'h0600, 1, 0); rdsr(st);
    check("R8 locked quarter: no busy, latch kept", 32'(st), 32'h06);
    read_mem(16'h0600, 1);
    check("R8 locked quarter unchanged", 32'(rxq[0]), 32'h3C);
    txq[0] = 8'hE7;
    write_mem(16'h01F0, 1, 0); wait_idle();
    read_mem(16'h01F0, 1);
    check("R8 unlocked region written", 32'(rxq[0]), 32'hE7);
    cmd1(8'h06); wrsr(8'h08); wait_idle();
    txq[0] = 8'h99;
    cmd1(8'h06); write_mem(16'h0400, 1, 0); cmd1(8'h04);
    read_mem(16'h0400, 1);
    check("R8 half lock covers 0x400", 32'(rxq[0]), 32'h11);
    cmd1(8'h06); wrsr(8'h00); wait_idle();
  endtask

  // R9: status lock qualified by wp_n
  task automatic t_status_lock();
    logic [7:0] st;
    cmd1(8'h06); wrsr(8'h84); wait_idle(); rdsr(st);
    check("R9 status lock bit written", 32'(st), 32'h84);
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h00); rdsr(st);
    check("R9 status write refused with wp_n low", 32'(st), 32'h86);
    wp_n = 1'b1;
    wrsr(8'h00); wait_idle(); rdsr(st);
    check("R9 status write allowed with wp_n high", 32'(st), 32'h00);
  endtask

  // R10: unknown command and deselect
  task automatic t_unknown();
    logic [7:0] d;
    cs_low(); xfer(8'hAB, d, 8); xfer(8'h00, d, 8); xfer(8'h00, d, 8);
    check("R10 unknown command keeps miso disabled", 32'(oe_seen), 32'd0);
    cs_high();
    check("R10 oe low with cs high", 32'(miso_oe), 32'd0);
  endtask

  // R12: mode 3
  task automatic t_mode3();
    logic [7:0] st;
    mode3 = 1'b1; sck = 1'b1; wclk(4);
    read_mem(16'h0105, 3);
    check("R12 mode 3 byte 0", 32'(rxq[0]), 32'h11);
    check("R12 mode 3 byte 2", 32'(rxq[2]), 32'h33);
    cmd1(8'h06); rdsr(st);
    check("R12 mode 3 enable", 32'(st), 32'h02);
    cmd1(8'h04); rdsr(st);
    check("R12 mode 3 disable", 32'(st), 32'h00);
    mode3 = 1'b0; sck = 1'b0; wclk(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; csn = 1'b0; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
    oe_seen = 1'b0;
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_wel();
    t_write_read();
    t_page_wrap();
    t_discard();
    t_busy_lock();
    t_read_wrap();
    t_protect();
    t_status_lock();
    t_unknown();
    t_mode3();
    summary();
    $finish;
  end
endmodule